// File: doc/BRIEF.md
# ADC Conversion Clock Generator

This block produces the conversion clock for an analog-to-digital converter controller. One conversion-clock period is the time to resolve one result bit. The clock comes from one of two sources. The first is the system clock, divided by an even ratio set by a 6-bit code: a code of N divides by 2×(N+1), so codes 0 to 63 span /2 to /128. The second is a free-running internal oscillator that reaches the block as an asynchronous clock. When the oscillator is selected, the divider code has no effect.

The output `conv_clk` is a gated, glitch-free clock. `tad_tick` is a one-cycle pulse in the system-clock domain, raised once per conversion period, for controllers that use a clock enable instead of the gated clock. `src_valid` reports that a source is cleanly enabled. While the sleep indicator is high, only the oscillator may run conversions. With the system-clock source selected in sleep, the output stops and `src_valid` falls.

A change of source is handled by a handover state machine clocked by the system clock. It has seven states:
- SW_SYS_ON: the divided system clock is being enabled.
- SW_SYS_RUN: the divided system clock drives the output.
- SW_SYS_OFF: the divided system clock is being disabled.
- SW_OSC_ON: the oscillator is being enabled.
- SW_OSC_RUN: the oscillator drives the output.
- SW_OSC_OFF: the oscillator is being disabled.
- SW_HALT: sleep with the system clock selected, so no source is enabled.

The transitions are:
- SYS_RUN to SYS_OFF on a request for the oscillator, and SYS_RUN to HALT on sleep.
- SYS_OFF to OSC_ON, HALT or SYS_ON once the system enable reads low.
- OSC_ON to OSC_RUN (or to OSC_OFF if the request was withdrawn) once the oscillator enable is acknowledged.
- OSC_RUN to OSC_OFF on a request for the system clock.
- OSC_OFF to HALT or SYS_ON once the acknowledge clears.
- SYS_ON to SYS_RUN once the system enable reads high, to SYS_OFF on a request for the oscillator, and to HALT on sleep.
- HALT to SYS_ON on wake, and HALT to OSC_ON on a request for the oscillator once the system enable is low.

Each enable is changed only while its own clock is low. Before the new source is enabled, the old one is confirmed off.

Top module: `adc_tad_clkgen`

## Requirements
- R1: While `rst_n` is low, `conv_clk`, `tad_tick` and `src_valid` are 0. After reset the system-clock source with code 0 is active, so the tick period is 2 system-clock cycles.
- R2: With `sel_osc`=0 and no sleep, `tad_tick` pulses once every 2×(code+1) system-clock cycles, where code is the unsigned value of `div_code`.
- R3: With the system-clock source, `conv_clk` is high for code+1 system-clock cycles of each 2×(code+1)-cycle period (50% duty).
- R4: A new `div_code` value is taken only at the end of the current half period. A half period already running completes with the old length.
- R5: With `sel_osc`=1, `tad_tick` pulses once per oscillator period and `div_code` has no effect on it.
- R6: With `sleep_req`=1 and `sel_osc`=0, `src_valid` is 0 from the second cycle on, and `tad_tick` and `conv_clk` stay 0.
- R7: With `sleep_req`=1 and `sel_osc`=1, the oscillator keeps producing ticks and `src_valid` stays 1.
- R8: The two source enables are never active together. `src_valid` is 1 only while exactly one source is enabled, and it returns to 1 within 200 system-clock cycles after a source change.
- R9: `tad_tick` is a single system-clock cycle wide. With the system-clock source it is raised in the cycle in which `conv_clk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_osc | input | 1 | Internal oscillator, asynchronous to clk_sys |
| sel_osc | input | 1 | 1 selects the oscillator, 0 the divided system clock |
| div_code | input | 6 | Divider code N, ratio 2×(N+1) |
| sleep_req | input | 1 | Device sleep indicator |
| conv_clk | output | 1 | Gated conversion clock |
| tad_tick | output | 1 | One-cycle pulse per conversion period (clk_sys domain) |
| src_valid | output | 1 | Selected source is enabled and running |

## Verification
On every cycle, the assertions check that the two enables are mutually exclusive, that `src_valid` implies an enabled source, and that sleep with the system source blocks the output. They also check that the counter stays within the latched code, that the code is latched only at terminal count, and that ticks are single-cycle and aligned with the rising edge. Only the bench scenarios can show the measured tick periods and the duty cycle across directed and random codes. The same holds for the old half period completing after a code change, for the oscillator period being unaffected by the divider code, and for recovery after sleep and source switches.

// File: rtl/adc_clkgen_pkg.sv
`timescale 1ns/1ps
package adc_clkgen_pkg;

    // Handover state machine between the two conversion-clock sources
    typedef enum logic [2:0] {
        SW_SYS_ON  = 3'd0,
        SW_SYS_RUN = 3'd1,
        SW_SYS_OFF = 3'd2,
        SW_OSC_ON  = 3'd3,
        SW_OSC_RUN = 3'd4,
        SW_OSC_OFF = 3'd5,
        SW_HALT    = 3'd6
    } sw_state_t;

    localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/adc_clkgen_sync.sv
`timescale 1ns/1ps
module adc_clkgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("adc_clkgen_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_clkgen_divider.sv
`timescale 1ns/1ps
module adc_clkgen_divider #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic              div_clk,
    output logic              rise
);
    logic [CODE_W-1:0] cnt;
    logic [CODE_W-1:0] cur_code;
    logic              term;

    // Half period ends when the counter reaches the latched code
    assign term = (cnt == cur_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_code <= '0;
            div_clk  <= 1'b0;
            rise     <= 1'b0;
        end else begin
            rise <= term & ~div_clk;
            if (term) begin
                cnt      <= '0;
                div_clk  <= ~div_clk;
                cur_code <= code_in;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cur_code); // R2
    AST_CODE_ONLY_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != cur_code) |=> $stable(cur_code)); // R4
    AST_TOGGLE_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_clk) |-> ($past(cnt) == $past(cur_code))); // R3
endmodule

// File: rtl/adc_clkgen_switch.sv
`timescale 1ns/1ps
module adc_clkgen_switch
    import adc_clkgen_pkg::*;
(
    input  logic      clk_sys,
    input  logic      clk_osc,
    input  logic      rst_n,
    input  logic      want_osc,
    input  logic      sleep_req,
    input  logic      div_clk,
    output logic      sys_en,
    output logic      osc_en,
    output logic      osc_ack,
    output logic      valid,
    output sw_state_t state
);
    sw_state_t state_nx;
    logic      req_sys;
    logic      req_osc;
    logic      osc_req_s;

    // State register
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            state <= SW_SYS_ON;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SW_SYS_ON: begin
                if (sleep_req && !want_osc) state_nx = SW_HALT;
                else if (want_osc)          state_nx = SW_SYS_OFF;
                else if (sys_en)            state_nx = SW_SYS_RUN;
            end
            SW_SYS_RUN: begin
                if (want_osc)       state_nx = SW_SYS_OFF;
                else if (sleep_req) state_nx = SW_HALT;
            end
            SW_SYS_OFF: begin
                if (!sys_en) begin
                    if (want_osc)       state_nx = SW_OSC_ON;
                    else if (sleep_req) state_nx = SW_HALT;
                    else                state_nx = SW_SYS_ON;
                end
            end
            SW_OSC_ON: begin
                if (osc_ack) state_nx = want_osc ? SW_OSC_RUN : SW_OSC_OFF;
            end
            SW_OSC_RUN: begin
                if (!want_osc) state_nx = SW_OSC_OFF;
            end
            SW_OSC_OFF: begin
                if (!osc_ack) state_nx = sleep_req ? SW_HALT : SW_SYS_ON;
            end
            SW_HALT: begin
                if (want_osc) begin
                    if (!sys_en) state_nx = SW_OSC_ON;
                end else if (!sleep_req) begin
                    state_nx = SW_SYS_ON;
                end
            end
            default: state_nx = SW_SYS_ON;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        req_sys = 1'b0;
        req_osc = 1'b0;
        valid   = 1'b0;
        unique case (state)
            SW_SYS_ON:  req_sys = 1'b1;
            SW_SYS_RUN: begin req_sys = 1'b1; valid = 1'b1; end
            SW_OSC_ON:  req_osc = 1'b1;
            SW_OSC_RUN: begin req_osc = 1'b1; valid = 1'b1; end
            default: ;
        endcase
    end

    // System-side enable changes on the falling system edge while the divided clock is low
    always_ff @(negedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            sys_en <= 1'b0;
        end else if (!div_clk) begin
            sys_en <= req_sys;
        end
    end

    // Oscillator-side request crosses into the oscillator domain
    adc_clkgen_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .d     (req_osc),
        .q     (osc_req_s)
    );

    // Oscillator enable changes only while the oscillator is low
    always_ff @(negedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            osc_en <= 1'b0;
        end else begin
            osc_en <= osc_req_s;
        end
    end

    // Acknowledge comes back into the system domain
    adc_clkgen_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk   (clk_sys),
        .rst_n (rst_n),
        .d     (osc_en),
        .q     (osc_ack)
    );

    AST_EN_EXCLUSIVE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !(sys_en && osc_ack)); // R8
    AST_VALID_HAS_SOURCE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        valid |-> (sys_en ^ osc_ack)); // R8
    AST_SLEEP_SYS_BLOCKED: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (sleep_req && !want_osc && $past(sleep_req && !want_osc)) |-> !valid); // R6
endmodule

// File: rtl/adc_tad_clkgen.sv
`timescale 1ns/1ps
module adc_tad_clkgen
    import adc_clkgen_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              clk_osc,
    input  logic              sel_osc,
    input  logic [CODE_W-1:0] div_code,
    input  logic              sleep_req,
    output logic              conv_clk,
    output logic              tad_tick,
    output logic              src_valid
);
    logic      div_clk;
    logic      div_rise;
    logic      sys_en;
    logic      osc_en;
    logic      osc_ack;
    logic      sw_valid;
    sw_state_t sw_state;
    logic      osc_s;
    logic      osc_s_d;
    logic      osc_edge;

    adc_clkgen_divider #(.CODE_W(CODE_W)) u_div (
        .clk     (clk_sys),
        .rst_n   (rst_n),
        .code_in (div_code),
        .div_clk (div_clk),
        .rise    (div_rise)
    );

    adc_clkgen_switch u_sw (
        .clk_sys   (clk_sys),
        .clk_osc   (clk_osc),
        .rst_n     (rst_n),
        .want_osc  (sel_osc),
        .sleep_req (sleep_req),
        .div_clk   (div_clk),
        .sys_en    (sys_en),
        .osc_en    (osc_en),
        .osc_ack   (osc_ack),
        .valid     (sw_valid),
        .state     (sw_state)
    );

    // Oscillator edge seen in the system domain for the tick output
    adc_clkgen_sync #(.STAGES(SYNC_DEPTH)) u_osc_smp (
        .clk   (clk_sys),
        .rst_n (rst_n),
        .d     (clk_osc),
        .q     (osc_s)
    );

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) osc_s_d <= 1'b0;
        else        osc_s_d <= osc_s;
    end

    assign osc_edge = osc_s & ~osc_s_d;

    // Output process
    always_comb begin
        conv_clk  = (div_clk & sys_en) | (clk_osc & osc_en);
        src_valid = sw_valid;
        tad_tick  = ((sw_state == SW_SYS_RUN) & div_rise & sys_en) |
                    ((sw_state == SW_OSC_RUN) & osc_edge);
    end

    AST_TICK_SINGLE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        tad_tick |=> !tad_tick); // R9
    AST_TICK_ON_RISE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (tad_tick && sys_en) |-> (div_clk && !$past(div_clk))); // R9
    AST_TICK_NEEDS_VALID: assert property (@(posedge clk_sys) disable iff (!rst_n)
        tad_tick |-> src_valid); // R6
endmodule

// File: tb/tb_adc_tad_clkgen.sv
`timescale 1ns/1ps
module tb_adc_tad_clkgen;
    logic       clk_sys = 1'b0;
    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       sel_osc;
    logic [5:0] div_code;
    logic       sleep_req;
    logic       conv_clk;
    logic       tad_tick;
    logic       src_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    adc_tad_clkgen dut (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .clk_osc   (clk_osc),
        .sel_osc   (sel_osc),
        .div_code  (div_code),
        .sleep_req (sleep_req),
        .conv_clk  (conv_clk),
        .tad_tick  (tad_tick),
        .src_valid (src_valid)
    );

    always #4 clk_sys = ~clk_sys;   // 125 MHz
    always #37 clk_osc = ~clk_osc;  // 74 ns oscillator, 9.25 system cycles

    function automatic int exp_period(input logic [5:0] c);
        return 2 * (int'(c) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the next tick is seen
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk_sys);
            n++;
        end while (!tad_tick && n < 3000);
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (!src_valid && n < 1000) begin
            @(negedge clk_sys);
            n++;
        end
    endtask

    // Settle on a code, then check period and duty
    task automatic sys_code_check(input logic [5:0] c);
        int n;
        int p;
        int h;
        div_code = c;
        next_tick(n);
        next_tick(n);
        next_tick(n);
        next_tick(n);
        p = exp_period(c);
        check(n == p, "R2 period", n, p);
        h = 0;
        for (int i = 0; i < p; i++) begin
            if (conv_clk) h++;
            @(negedge clk_sys);
        end
        check(h == int'(c) + 1, "R3 high cycles", h, int'(c) + 1);
    endtask

    initial begin
        int n;
        int h;
        int lo;
        int ticks;
        int highs;
        int wid;
        void'($urandom(32'h5EED_0042));
        rst_n     = 1'b0;
        sel_osc   = 1'b0;
        div_code  = 6'd0;
        sleep_req = 1'b0;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_sys);
            check(!conv_clk && !tad_tick && !src_valid, "R1 reset outputs",
                  {conv_clk, tad_tick, src_valid}, 0);
        end
        rst_n = 1'b1;
        wait_valid(n);
        check(src_valid, "R1 valid after reset", n, 20);
        next_tick(n);
        next_tick(n);
        check(n == 2, "R1 period after reset", n, 2);

        // R9 tick width and alignment
        wid = 0;
        next_tick(n);
        check(conv_clk == 1'b1, "R9 conv_clk high at tick", conv_clk, 1);
        @(negedge clk_sys);
        check(tad_tick == 1'b0, "R9 tick one cycle", tad_tick, 0);

        // R2/R3 directed corners
        sys_code_check(6'd1);
        sys_code_check(6'd3);
        sys_code_check(6'd7);
        sys_code_check(6'd63);
        // R2/R3 random codes
        for (int k = 0; k < 6; k++) begin
            sys_code_check(6'($urandom_range(0, 63)));
        end

        // R4 code change during a high half period
        div_code = 6'd3;
        next_tick(n); next_tick(n); next_tick(n);
        div_code = 6'd0;
        h = 0;
        while (conv_clk && h < 100) begin
            h++;
            @(negedge clk_sys);
        end
        check(h == 4, "R4 old half period kept", h, 4);
        lo = 0;
        while (!conv_clk && lo < 100) begin
            lo++;
            @(negedge clk_sys);
        end
        check(lo == 1, "R4 new half period", lo, 1);

        // R5/R8 switch to oscillator
        sel_osc = 1'b1;
        @(negedge clk_sys);
        @(negedge clk_sys);
        check(!src_valid, "R8 valid low in handover", src_valid, 0);
        wait_valid(n);
        check(src_valid && n <= 200, "R8 osc valid within bound", n, 200);
        next_tick(n);
        next_tick(n);
        check(n == 9 || n == 10, "R5 osc period", n, 9);
        div_code = 6'd63;
        next_tick(n);
        next_tick(n);
        check(n == 9 || n == 10, "R5 code ignored", n, 9);
        div_code = 6'($urandom_range(0, 63));
        next_tick(n);
        next_tick(n);
        check(n == 9 || n == 10, "R5 random code ignored", n, 9);

        // R7 sleep with oscillator
        sleep_req = 1'b1;
        ticks = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_sys);
            if (tad_tick) ticks++;
            if (!src_valid) ticks = -1000;
        end
        check(ticks >= 9 && ticks <= 12, "R7 osc ticks in sleep", ticks, 10);

        // R6 sleep with system clock selected
        div_code = 6'd2;
        sel_osc  = 1'b0;
        for (int i = 0; i < 60; i++) @(negedge clk_sys);
        check(!src_valid, "R6 valid low", src_valid, 0);
        ticks = 0;
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk_sys);
            if (tad_tick) ticks++;
            if (conv_clk) highs++;
        end
        check(ticks == 0, "R6 no ticks", ticks, 0);
        check(highs == 0, "R6 conv_clk low", highs, 0);

        // R8/R2 wake up
        sleep_req = 1'b0;
        wait_valid(n);
        check(src_valid && n <= 200, "R8 sys valid after wake", n, 200);
        next_tick(n);
        next_tick(n);
        check(n == exp_period(6'd2), "R2 period after wake", n, exp_period(6'd2));

        // R8 back and forth
        sel_osc = 1'b1;
        wait_valid(n);
        for (int i = 0; i < 3; i++) @(negedge clk_sys);
        sel_osc = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk_sys);
        wait_valid(n);
        check(src_valid && n <= 200, "R8 return to sys", n, 200);
        sys_code_check(6'd5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_200_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule